// File: doc/BRIEF.md
# I2C Bidirectional Data Shift Register

This block is the byte-wide data register that sits on the SDA side of an I2C controller. A controller stream-loads a byte to send, and the register drives that byte onto the bus one bit at a time, most significant bit first. The same register also captures the bus. At every SCL-high sample the controller presents the sampled SDA level, and the register shifts that level into its low end. As a result it always holds the last eight bits that were really on the wire.

Transmit and receive share one path. A master that loses arbitration part way through a byte does not need to recover anything: once the byte ends, the register already holds the winning master's data. Clock generation, arbitration decisions and the acknowledge bit belong to the surrounding controller.

A sample is taken while SCL is high but is held back until SCL goes low. Only then does the register shift. This way the serial output never moves during the high phase.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset, `rd_data` is 8'hFF, `sda_out` is 1 (line released) and `byte_done` is 0.
- R2: A byte on `load_data` is taken in a cycle where both `load_valid` and `load_ready` are high. `load_ready` is high exactly while `scl_level` is low. The taken byte appears on `rd_data` in the next cycle. While `scl_level` is high, `load_valid` has no effect on `rd_data`.
- R3: `sda_out` always equals `rd_data[7]`. Bit 7 of a loaded byte is therefore the first bit driven.
- R4: A `sample_stb` pulse records `sda_in`. In the first clock edge at which `scl_level` is low afterwards, `rd_data` becomes `{rd_data[6:0], recorded_bit}`, so data moves from bit 0 toward bit 7.
- R5: After eight samples, the first sampled bit sits in `rd_data[7]` and the last sampled bit sits in `rd_data[0]`.
- R6: Shifting in continues while a loaded byte is being sent. After eight bits, `rd_data` holds the sampled bus levels, not the loaded byte, wherever the two differ.
- R7: `byte_done` is a single-cycle pulse. It is high in the cycle in which the eighth shift since the last load (or since the previous `byte_done`) becomes visible on `rd_data`, and never otherwise.
- R8: An accepted load restarts the bit count, so the next `byte_done` needs eight further shifts.
- R9: When a load is accepted in the same cycle that a recorded bit would shift in, the load wins. The recorded bit is discarded and is not counted.
- R10: `sda_out` changes only at clock edges where `scl_level` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | A transmit byte is offered |
| load_ready | output | 1 | The register can take the offered byte |
| load_data | input | 8 | Byte to transmit |
| scl_level | input | 1 | Current SCL level as seen by the controller |
| sample_stb | input | 1 | One-cycle strobe at the SCL-high sample point |
| sda_in | input | 1 | Sampled SDA level, valid with `sample_stb` |
| sda_out | output | 1 | Serial data to drive on SDA (1 = release) |
| rd_data | output | 8 | Parallel view of the register |
| byte_done | output | 1 | Eighth bit of a byte has shifted in |

## Verification
The assertions rely on three properties of the inputs:
- `sample_stb` is raised only while `scl_level` is high.
- There is at most one strobe per SCL high phase.
- `scl_level` does not return low in the same cycle as the strobe.

Under these conditions, every recorded bit is still pending when the low phase begins. The bench keeps to this by driving each bit as a fixed pattern of four clock cycles: SCL rises together with the strobe, the strobe drops, SCL falls, then a settle cycle follows. Loads are offered only during SCL low, except for one deliberate attempt while SCL is high, which checks that the load is ignored.

// File: rtl/i2c_shf_pkg.sv
package i2c_shf_pkg;
  parameter int unsigned SHF_W_DEF = 8;

  function automatic int unsigned cnt_bits(input int unsigned w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/shf_sample_hold.sv
module shf_sample_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic sda_in,
  input  logic scl_level,
  input  logic flush,
  output logic pend_bit,
  output logic commit
);
  logic pend_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      pend_bit <= 1'b1;
    end else if (flush) begin
      pend_vld <= 1'b0;
    end else if (sample_stb) begin
      pend_vld <= 1'b1;
      pend_bit <= sda_in;
    end else if (commit) begin
      pend_vld <= 1'b0;
    end
  end

  // a recorded bit is released into the register only during SCL low
  assign commit = pend_vld & ~scl_level;
endmodule

// File: rtl/shf_bit_counter.sv
module shf_bit_counter #(
  parameter int unsigned W = i2c_shf_pkg::SHF_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic done
);
  localparam int unsigned CW = i2c_shf_pkg::cnt_bits(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      done <= (cnt == LAST);
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/shf_data_reg.sv
module shf_data_reg #(
  parameter int unsigned W = i2c_shf_pkg::SHF_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  input  logic         shift_bit,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '1;
    else if (load)   q <= load_data;
    else if (shift)  q <= {q[W-2:0], shift_bit};
  end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
  parameter int unsigned W = i2c_shf_pkg::SHF_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  input  logic         scl_level,
  input  logic         sample_stb,
  input  logic         sda_in,
  output logic         sda_out,
  output logic [W-1:0] rd_data,
  output logic         byte_done
);
  logic load_fire;
  logic commit;
  logic pend_bit;
  logic do_shift;

  assign load_ready = ~scl_level;
  assign load_fire  = load_valid & load_ready;
  // load has priority; a colliding recorded bit is dropped
  assign do_shift   = commit & ~load_fire;

  shf_sample_hold u_hold (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sda_in(sda_in),
    .scl_level(scl_level), .flush(load_fire), .pend_bit(pend_bit), .commit(commit)
  );

  shf_bit_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(load_fire), .step(do_shift), .done(byte_done)
  );

  shf_data_reg #(.W(W)) u_reg (
    .clk(clk), .rst_n(rst_n), .load(load_fire), .load_data(load_data),
    .shift(do_shift), .shift_bit(pend_bit), .q(rd_data)
  );

  assign sda_out = rd_data[W-1];
endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_valid,
  input logic         load_ready,
  input logic [W-1:0] load_data,
  input logic         scl_level,
  input logic         sda_out,
  input logic [W-1:0] rd_data,
  input logic         byte_done
);
  assert_load_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> rd_data == $past(load_data));

  assert_done_shifted_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> rd_data[W-1:1] == $past(rd_data[W-2:0]));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  assert_sda_low_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_out != $past(sda_out)) |-> !$past(scl_level));
endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
  .load_data(load_data), .scl_level(scl_level), .sda_out(sda_out),
  .rd_data(rd_data), .byte_done(byte_done)
);

// File: tb/i2c_byte_shifter_tb.sv
module i2c_byte_shifter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [7:0] load_data = 8'h00;
  logic       scl_level = 1'b0;
  logic       sample_stb = 1'b0;
  logic       sda_in = 1'b1;
  logic       sda_out;
  logic [7:0] rd_data;
  logic       byte_done;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_reg = 8'hFF;
  int bits_since = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  i2c_byte_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .scl_level(scl_level), .sample_stb(sample_stb),
    .sda_in(sda_in), .sda_out(sda_out), .rd_data(rd_data), .byte_done(byte_done)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: scoreboard on byte_done, R7 pulse width, R10 output stability
  logic prev_sda = 1'b1;
  logic prev_scl = 1'b0;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_out != prev_sda) chk(!prev_scl, "R10", {7'd0, sda_out}, {7'd0, prev_sda});
      if (prev_done) chk(!byte_done, "R7 pulse", {7'd0, byte_done}, 8'd0);
      if (byte_done) begin
        chk(bits_since == 8, "R7/R8 count", 8'(bits_since), 8'd8);
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected", rd_data, 8'hxx);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R5/R6 byte", rd_data, e);
        end
        bits_since = 0;
      end
    end
    prev_sda  = sda_out;
    prev_scl  = scl_level;
    prev_done = byte_done;
  end

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk) load_valid = 1'b1; load_data = d;
    @(negedge clk) load_valid = 1'b0;
    exp_reg = d; bits_since = 0;
    chk(rd_data == d, "R2 load", rd_data, d);
  endtask

  task automatic drive_bit(input logic b);
    chk(sda_out == exp_reg[7], "R3 sda_out", {7'd0, sda_out}, {7'd0, exp_reg[7]});
    @(negedge clk) scl_level = 1'b1; sample_stb = 1'b1; sda_in = b;
    @(negedge clk) sample_stb = 1'b0;
    @(negedge clk) scl_level = 1'b0;
    @(negedge clk);
    exp_reg = {exp_reg[6:0], b};
    bits_since++;
    chk(rd_data == exp_reg, "R4 shift", rd_data, exp_reg);
  endtask

  task automatic bus_byte(input logic [7:0] bus);
    exp_q.push_back(bus);
    for (int i = 7; i >= 0; i--) drive_bit(bus[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd_data == 8'hFF, "R1 rd_data", rd_data, 8'hFF);
    chk(sda_out == 1'b1, "R1 sda_out", {7'd0, sda_out}, 8'd1);
    chk(byte_done == 1'b0, "R1 byte_done", {7'd0, byte_done}, 8'd0);
    chk(load_ready == 1'b1, "R2 ready low phase", {7'd0, load_ready}, 8'd1);

    // R2: ignored while SCL high
    @(negedge clk) scl_level = 1'b1;
    @(negedge clk);
    chk(load_ready == 1'b0, "R2 ready high phase", {7'd0, load_ready}, 8'd0);
    load_valid = 1'b1; load_data = 8'h12;
    @(negedge clk) load_valid = 1'b0;
    chk(rd_data == 8'hFF, "R2 ignored", rd_data, 8'hFF);
    scl_level = 1'b0;
    @(negedge clk);

    // transmit with bus echo (R3, R5)
    load_byte(8'hA5);
    bus_byte(8'hA5);
    // lost arbitration: sent FF, bus carries 3C (R6)
    load_byte(8'hFF);
    bus_byte(8'h3C);
    // plain receive, first bit lands in bit 7 (R5)
    bus_byte(8'h81);
    chk(rd_data[7] == 1'b1 && rd_data[0] == 1'b1, "R5 order", rd_data, 8'h81);

    // R8: reload mid-byte restarts count
    load_byte(8'h00);
    for (int i = 0; i < 3; i++) drive_bit(1'b1);
    load_byte(8'hC3);
    bus_byte(8'h6E);

    // R9: load collides with pending bit
    load_byte(8'h00);
    @(negedge clk) scl_level = 1'b1; sample_stb = 1'b1; sda_in = 1'b1;
    @(negedge clk) sample_stb = 1'b0;
    @(negedge clk) scl_level = 1'b0; load_valid = 1'b1; load_data = 8'h5A;
    @(negedge clk) load_valid = 1'b0;
    exp_reg = 8'h5A; bits_since = 0;
    chk(rd_data == 8'h5A, "R9 load wins", rd_data, 8'h5A);
    @(negedge clk);
    chk(rd_data == 8'h5A, "R9 bit dropped", rd_data, 8'h5A);
    bus_byte(8'hB7);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all bytes done", 8'(exp_q.size()), 8'd0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule